// File: doc/BRIEF.md
# Serial Converter Sample Reader

This block is the bus-master side of a three-wire serial link to a successive-approximation converter. Each conversion frame starts when chip select is pulled low. The block then runs a serial clock that idles high, shifts in the converter's output bits on one line, and releases chip select again. When the frame ends, the block presents a right-aligned 12-bit sample together with a one-cycle valid strobe. The serial clock is made by dividing the system clock: every half period lasts `HALF_DIV` system cycles. The default of 8 gives about 6 MHz from a 100 MHz system clock.

There are two sampling modes. In mode 0 the line is captured on falling serial-clock edges, and the frame word is aligned by dropping two bits. In mode 1 the line is captured on rising edges, and three bits are dropped. Mode 0 frames every word with chip select by itself, so one start command can run a burst of back-to-back samples. Mode 1 performs exactly one framed transfer per start command. After either kind of transfer, the block can send a short 8-clock frame that lifts chip select before the tenth falling edge. This puts the converter into its power-down state. A done pulse marks the end of the whole command.

The sequencer uses these states: `ST_IDLE`, `ST_LEAD`, `ST_CLK_LO`, `ST_CLK_HI`, `ST_GAP` and `ST_FINISH`.
- `ST_IDLE` goes to `ST_LEAD` when a start arrives and there is at least one frame to send. It goes to `ST_FINISH` when a start arrives with nothing to send.
- `ST_LEAD` lasts half a period with chip select low and the clock high, then goes to `ST_CLK_LO`.
- `ST_CLK_LO` goes to `ST_CLK_HI`.
- `ST_CLK_HI` goes back to `ST_CLK_LO` until the frame's last clock, then goes to `ST_GAP`.
- `ST_GAP` goes to `ST_LEAD` while sample frames or a power-down frame are still pending, and otherwise to `ST_FINISH`.
- `ST_FINISH` goes to `ST_IDLE` after one cycle.

Top module: `spi_adc_reader`

## Requirements
- R1: After reset, and whenever the block is idle, `cs_n` and `sclk` are 1, and `sample_valid`, `busy` and `done` are 0.
- R2: `sclk` is 1 whenever `cs_n` is 1. Every low phase of `sclk` lasts exactly `HALF_DIV` clock cycles. A sample frame holds `cs_n` low across exactly 16 falling edges of `sclk`.
- R3: In mode 0 (`phase_mode`=0), the sample equals the `miso` levels present at falling edges 3 to 14 of the frame, first edge to MSB. This is the 16-bit word captured on falling edges, shifted right by 2.
- R4: In mode 1 (`phase_mode`=1), the sample equals the `miso` levels present at rising edges 2 to 13 of the frame, first edge to MSB. This is the 16-bit word captured on rising edges, shifted right by 3.
- R5: In mode 0, a start with `count`=N produces N sample frames, each in its own `cs_n` low period. Each frame yields exactly one `sample_valid` pulse, raised in the cycle in which `cs_n` returns to 1.
- R6: Between two frames, `cs_n` stays 1 for at least 2*`HALF_DIV` cycles, which is one serial clock period.
- R7: In mode 1, `count` is ignored and each start produces exactly one sample frame.
- R8: If `pd_req` is 1 at start, one extra frame follows the sample frames. This frame has exactly 8 falling edges of `sclk` and raises no `sample_valid`. With `count`=0 in mode 0, it is the only frame sent.
- R9: `done` pulses for one cycle after the last frame of a command, and `busy` is 0 in the next cycle. A start with `count`=0 in mode 0 and `pd_req`=0 gives `done` without any frame.
- R10: A `start` while `busy` is 1 is ignored. The running command keeps its count, mode and power-down choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (taken only when idle) |
| count | input | CNT_W | Number of samples in mode 0 |
| phase_mode | input | 1 | 0: falling-edge capture, burst; 1: rising-edge capture, single |
| pd_req | input | 1 | Append the power-down frame |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| sample | output | SAMPLE_W | Aligned sample |
| sample_valid | output | 1 | One-cycle strobe for `sample` |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
The assertions assume that `start` is only acted on when the block is idle and that `miso` changes only after a falling `sclk` edge, as a converter drives it. The gap and edge-count checks also assume that `HALF_DIV` does not change during a run. The bench models the converter as a stream of two zeros, 12 random data bits and two zeros. The stream is restarted at each chip-select fall and advanced after each falling clock edge, so the `miso` changes never coincide with a capture edge. Commands are issued only at falling system-clock edges. The one deliberate start pulse sent while busy is a directed case.

// File: rtl/spi_adc_pkg.sv
package spi_adc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_GAP,
        ST_FINISH
    } seq_state_t;

    // alignment: bits discarded below the sample in each capture mode
    localparam int SHIFT_FALL = 2;
    localparam int SHIFT_RISE = 3;

endpackage

// File: rtl/spi_adc_timer.sv
module spi_adc_timer #(
    parameter int HALF_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_long,
    output logic expired
);
    localparam int TMR_W = (2 * HALF_DIV > 1) ? $clog2(2 * HALF_DIV) : 1;
    localparam logic [TMR_W-1:0] HALF_LAST = TMR_W'(HALF_DIV - 1);
    localparam logic [TMR_W-1:0] FULL_LAST = TMR_W'(2 * HALF_DIV - 1);

    logic [TMR_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_long ? FULL_LAST : HALF_LAST;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/spi_adc_capture.sv
module spi_adc_capture #(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                cap_en,
    input  logic                miso,
    input  logic                mode,
    input  logic                emit,
    output logic [SAMPLE_W-1:0] sample,
    output logic                sample_valid
);
    import spi_adc_pkg::*;

    // keep only as many captured bits as the wider alignment needs
    localparam int KEEP_W = SAMPLE_W + SHIFT_RISE;

    logic [KEEP_W-1:0]   shreg;
    logic [SAMPLE_W-1:0] aligned;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (clear) begin
            shreg <= '0;
        end else if (cap_en) begin
            shreg <= {shreg[KEEP_W-2:0], miso};
        end
    end

    generate
        if (SHIFT_RISE > SHIFT_FALL) begin : g_align
            always_comb begin
                if (mode) begin
                    aligned = shreg[SAMPLE_W+SHIFT_RISE-1:SHIFT_RISE];
                end else begin
                    aligned = shreg[SAMPLE_W+SHIFT_FALL-1:SHIFT_FALL];
                end
            end
        end else begin : g_align_eq
            assign aligned = shreg[SAMPLE_W+SHIFT_RISE-1:SHIFT_RISE];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample       <= '0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= emit;
            if (emit) begin
                sample <= aligned;
            end
        end
    end

endmodule

// File: rtl/spi_adc_seq.sv
module spi_adc_seq #(
    parameter int FRAME_BITS = 16,
    parameter int PD_BITS    = 8,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    input  logic             phase_mode,
    input  logic             pd_req,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic             tmr_long,
    output logic             cap_clear,
    output logic             cap_en,
    output logic             cap_emit,
    output logic             mode_q,
    output logic             cs_n,
    output logic             sclk,
    output logic             busy,
    output logic             done
);
    import spi_adc_pkg::*;

    localparam int BIT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam logic [BIT_W-1:0] LAST_DATA = BIT_W'(FRAME_BITS - 1);
    localparam logic [BIT_W-1:0] LAST_PD   = BIT_W'(PD_BITS - 1);

    seq_state_t       state, state_n;
    logic [BIT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] remain;
    logic             pd_pend;
    logic             pd_frame;

    logic             accept;
    logic [CNT_W-1:0] src_rem;
    logic             src_pd;
    logic             enter_lead;
    logic             last_clk;
    logic             fall_edge;
    logic             rise_edge;

    assign accept   = (state == ST_IDLE) && start;
    assign src_rem  = (state == ST_IDLE) ? (phase_mode ? CNT_W'(1) : count) : remain;
    assign src_pd   = (state == ST_IDLE) ? pd_req : pd_pend;
    assign last_clk = (bit_cnt == (pd_frame ? LAST_PD : LAST_DATA));

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (src_rem != '0 || src_pd) state_n = ST_LEAD;
                    else                         state_n = ST_FINISH;
                end
            end
            ST_LEAD:   if (tmr_expired) state_n = ST_CLK_LO;
            ST_CLK_LO: if (tmr_expired) state_n = ST_CLK_HI;
            ST_CLK_HI: begin
                if (tmr_expired) state_n = last_clk ? ST_GAP : ST_CLK_LO;
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    state_n = (remain != '0 || pd_pend) ? ST_LEAD : ST_FINISH;
                end
            end
            ST_FINISH: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    assign enter_lead = (state_n == ST_LEAD) && (state != ST_LEAD);
    assign fall_edge  = (state == ST_LEAD || state == ST_CLK_HI) && (state_n == ST_CLK_LO);
    assign rise_edge  = (state == ST_CLK_LO) && (state_n == ST_CLK_HI);

    assign tmr_load  = (state_n != state);
    assign tmr_long  = (state_n == ST_GAP);
    assign cap_clear = enter_lead;
    assign cap_en    = !pd_frame && (mode_q ? rise_edge : fall_edge);
    assign cap_emit  = !pd_frame && (state == ST_CLK_HI) && (state_n == ST_GAP);

    // state register and command bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            remain   <= '0;
            pd_pend  <= 1'b0;
            pd_frame <= 1'b0;
            mode_q   <= 1'b0;
        end else begin
            state <= state_n;
            if (accept) begin
                mode_q <= phase_mode;
            end
            if (enter_lead) begin
                bit_cnt <= '0;
                if (src_rem != '0) begin
                    remain   <= src_rem - 1'b1;
                    pd_pend  <= src_pd;
                    pd_frame <= 1'b0;
                end else begin
                    remain   <= '0;
                    pd_pend  <= 1'b0;
                    pd_frame <= 1'b1;
                end
            end else begin
                if (accept) begin
                    remain  <= src_rem;
                    pd_pend <= src_pd;
                end
                if (state == ST_CLK_HI && state_n == ST_CLK_LO) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // registered pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n <= 1'b1;
            sclk <= 1'b1;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            cs_n <= !(state_n == ST_LEAD || state_n == ST_CLK_LO || state_n == ST_CLK_HI);
            sclk <= (state_n != ST_CLK_LO);
            busy <= (state_n != ST_IDLE);
            done <= (state_n == ST_FINISH);
        end
    end

endmodule

// File: rtl/spi_adc_reader.sv
module spi_adc_reader #(
    parameter int HALF_DIV   = 8,
    parameter int FRAME_BITS = 16,
    parameter int PD_BITS    = 8,
    parameter int SAMPLE_W   = 12,
    parameter int CNT_W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CNT_W-1:0]    count,
    input  logic                phase_mode,
    input  logic                pd_req,
    input  logic                miso,
    output logic                cs_n,
    output logic                sclk,
    output logic [SAMPLE_W-1:0] sample,
    output logic                sample_valid,
    output logic                busy,
    output logic                done
);
    logic tmr_expired;
    logic tmr_load;
    logic tmr_long;
    logic cap_clear;
    logic cap_en;
    logic cap_emit;
    logic mode_q;

    spi_adc_timer #(
        .HALF_DIV (HALF_DIV)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tmr_load),
        .load_long (tmr_long),
        .expired   (tmr_expired)
    );

    spi_adc_seq #(
        .FRAME_BITS (FRAME_BITS),
        .PD_BITS    (PD_BITS),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .count       (count),
        .phase_mode  (phase_mode),
        .pd_req      (pd_req),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_long    (tmr_long),
        .cap_clear   (cap_clear),
        .cap_en      (cap_en),
        .cap_emit    (cap_emit),
        .mode_q      (mode_q),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .busy        (busy),
        .done        (done)
    );

    spi_adc_capture #(
        .SAMPLE_W (SAMPLE_W)
    ) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (cap_clear),
        .cap_en       (cap_en),
        .miso         (miso),
        .mode         (mode_q),
        .emit         (cap_emit),
        .sample       (sample),
        .sample_valid (sample_valid)
    );

endmodule

// File: rtl/spi_adc_reader_chk.sv
module spi_adc_reader_chk #(
    parameter int HALF_DIV   = 8,
    parameter int FRAME_BITS = 16
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic sample_valid,
    input logic busy,
    input logic done
);
    localparam int GAP_MIN = 2 * HALF_DIV;
    localparam int GC_W    = $clog2(GAP_MIN + 1);
    localparam int FC_W    = $clog2(FRAME_BITS + 2);

    logic [GC_W-1:0] hi_cnt;
    logic [FC_W-1:0] fall_cnt;
    logic            sclk_d;
    logic            cs_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt   <= GC_W'(GAP_MIN);
            fall_cnt <= '0;
            sclk_d   <= 1'b1;
            cs_d     <= 1'b1;
        end else begin
            sclk_d <= sclk;
            cs_d   <= cs_n;
            if (cs_n) begin
                if (hi_cnt < GC_W'(GAP_MIN)) hi_cnt <= hi_cnt + 1'b1;
            end else begin
                hi_cnt <= '0;
            end
            if (cs_d && !cs_n) begin
                fall_cnt <= '0;
            end else if (!cs_n && sclk_d && !sclk && fall_cnt < FC_W'(FRAME_BITS + 1)) begin
                fall_cnt <= fall_cnt + 1'b1;
            end
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && sclk && !sample_valid));

    p_sclk_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    p_fall_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_cnt <= FC_W'(FRAME_BITS));

    p_valid_at_cs_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (cs_n && !cs_d));

    p_cs_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_d && !cs_n) |-> (hi_cnt >= GC_W'(GAP_MIN)));

    p_valid_full_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (fall_cnt == FC_W'(FRAME_BITS)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_then_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

bind spi_adc_reader spi_adc_reader_chk #(
    .HALF_DIV   (HALF_DIV),
    .FRAME_BITS (FRAME_BITS)
) u_chk (.*);

// File: tb/tb_spi_adc_reader.sv
`timescale 1ns/1ps
module tb_spi_adc_reader;
    localparam int HALF_DIV = 8;
    localparam int CNT_W    = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] count = '0;
    logic             phase_mode = 1'b0;
    logic             pd_req = 1'b0;
    logic             miso;
    logic             cs_n;
    logic             sclk;
    logic [11:0]      sample;
    logic             sample_valid;
    logic             busy;
    logic             done;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    spi_adc_reader #(.HALF_DIV(HALF_DIV), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .count(count),
        .phase_mode(phase_mode), .pd_req(pd_req), .miso(miso),
        .cs_n(cs_n), .sclk(sclk), .sample(sample),
        .sample_valid(sample_valid), .busy(busy), .done(done)
    );

    // converter model: two zeros, 12 data bits, two zeros; advances after each falling sclk
    logic        mon_on = 1'b0;
    logic        in_frame = 1'b0;
    logic [15:0] stream = '0;
    logic [11:0] cur_d = '0;
    int          idx = 0;
    int          falls = 0;

    logic [11:0] frame_d_q[$];
    int          frame_f_q[$];
    logic [11:0] samp_q[$];
    int          done_cnt = 0;
    int          gap_err = 0;
    int          low_err = 0;

    assign miso = (in_frame && idx < 16) ? stream[15-idx] : 1'b0;

    always @(negedge cs_n, posedge cs_n, negedge sclk) begin
        if (cs_n) begin
            if (in_frame && mon_on) begin
                frame_d_q.push_back(cur_d);
                frame_f_q.push_back(falls);
            end
            in_frame = 1'b0;
        end else if (!in_frame) begin
            cur_d    = 12'($urandom());
            stream   = {2'b00, cur_d, 2'b00};
            idx      = 0;
            falls    = 0;
            in_frame = 1'b1;
        end else begin
            falls = falls + 1;
            idx   = idx + 1;
        end
    end

    // cycle monitor, sampled away from the active edge
    int  low_run = 0;
    int  hi_run = 1000;
    logic sclk_p = 1'b1;
    logic cs_p = 1'b1;
    always @(negedge clk) begin
        if (mon_on) begin
            if (sample_valid) samp_q.push_back(sample);
            if (done) done_cnt = done_cnt + 1;
            if (!sclk) low_run = low_run + 1;
            if (sclk && !sclk_p) begin
                if (low_run != HALF_DIV) low_err = low_err + 1;
                low_run = 0;
            end
            if (cs_n) hi_run = hi_run + 1;
            if (!cs_n && cs_p) begin
                if (hi_run < 2 * HALF_DIV) gap_err = gap_err + 1;
                hi_run = 0;
            end
        end
        sclk_p = sclk;
        cs_p   = cs_n;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_samples(input bit m, input int n);
        return m ? 1 : n;
    endfunction

    task automatic run_cmd(input bit m, input int n, input bit pd, input bit poke);
        int ns;
        int waited;
        frame_d_q.delete();
        frame_f_q.delete();
        samp_q.delete();
        done_cnt = 0;
        gap_err  = 0;
        low_err  = 0;
        @(negedge clk);
        phase_mode = m;
        count      = CNT_W'(n);
        pd_req     = pd;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            phase_mode = !m;
            count      = CNT_W'(7);
            pd_req     = !pd;
            start      = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (done_cnt == 0 && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        chk(waited < 20000, "R9", "done seen before timeout", waited, 0);
        repeat (3) @(negedge clk);
        ns = exp_samples(m, n);
        chk(samp_q.size() == ns, m ? "R7" : "R5", "sample count", samp_q.size(), ns);
        chk(frame_f_q.size() == ns + int'(pd), "R8", "frame count", frame_f_q.size(), ns + int'(pd));
        for (int i = 0; i < frame_f_q.size(); i++) begin
            if (i < ns) chk(frame_f_q[i] == 16, "R2", "falls in sample frame", frame_f_q[i], 16);
            else        chk(frame_f_q[i] == 8,  "R8", "falls in power-down frame", frame_f_q[i], 8);
        end
        for (int i = 0; i < samp_q.size() && i < frame_d_q.size(); i++) begin
            chk(samp_q[i] == frame_d_q[i], m ? "R4" : "R3", "sample value",
                int'(samp_q[i]), int'(frame_d_q[i]));
        end
        chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
        chk(busy == 1'b0 && cs_n == 1'b1, "R1", "idle after done", int'(busy), 0);
        chk(gap_err == 0, "R6", "short cs_n gaps", gap_err, 0);
        chk(low_err == 0, "R2", "sclk low phase errors", low_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(cs_n == 1'b1 && sclk == 1'b1, "R1", "pins in reset", int'({cs_n, sclk}), 3);
        chk(!sample_valid && !busy && !done, "R1", "strobes in reset",
            int'({sample_valid, busy, done}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        mon_on = 1'b1;
        chk(cs_n == 1'b1 && sclk == 1'b1 && !busy, "R1", "idle after release",
            int'({cs_n, sclk, busy}), 6);

        run_cmd(1'b0, 1, 1'b0, 1'b0);   // R3 single sample
        run_cmd(1'b0, 4, 1'b0, 1'b0);   // R5 burst
        run_cmd(1'b1, 5, 1'b0, 1'b0);   // R7 count ignored in mode 1
        run_cmd(1'b0, 2, 1'b1, 1'b0);   // R8 power-down after burst
        run_cmd(1'b1, 1, 1'b1, 1'b0);   // R4 + R8
        run_cmd(1'b0, 0, 1'b1, 1'b0);   // R8 power-down only
        run_cmd(1'b0, 0, 1'b0, 1'b0);   // R9 empty command
        run_cmd(1'b0, 3, 1'b0, 1'b1);   // R10 start while busy ignored
        run_cmd(1'b1, 2, 1'b1, 1'b1);   // R10 in mode 1
        for (int k = 0; k < 8; k++) begin
            run_cmd(1'($urandom() % 2), int'($urandom() % 4), 1'($urandom() % 2), 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule